// File: doc/BRIEF.md
# Capture/Compare Timer with Match Outputs

A 16-bit free-running timer with four capture latches and three compare registers. The timer advances on every clock, or, when selected, once per rising edge of an external event input. A rising edge on a dedicated timer-reset input returns the count to zero.

Each capture input copies the current count into its own latch. Software picks which edges qualify for each channel. Each compare register is checked against the next count value whenever the timer advances. A match then sets, clears or toggles bits of an eight-bit output bus. Six of those bits follow set/clear masks. The top two bits invert on their own compare register.

Every capture and every match raises a sticky interrupt flag, which is cleared by writing one. All external inputs pass through two synchroniser flops before edge detection. Software uses a simple write port and a combinational read port.

Top module: `cct_timer`

## Requirements
- R1: With the clock source select (control register, address 0, bit 0) at 0, the timer increments by one on every clock cycle.
- R2: With the clock source select at 1, the timer increments once per rising edge of `ev_i` and holds otherwise, including while `ev_i` stays high.
- R3: A rising edge on `trst_i` clears the timer to zero; this takes priority over counting.
- R4: Capture channel n copies the timer into its latch on each edge enabled in the edge register (address 1, bits 2n+1:2n; bit 2n = rising, bit 2n+1 = falling). A non-enabled edge leaves the latch unchanged. Latches are read at addresses 10 to 13.
- R5: When the timer advances onto the value of compare register 0 (address 2), each output bit 0..5 that is set in both the set mask (address 5) and the enable mask (address 7) goes high. Non-enabled bits are unchanged.
- R6: When the timer advances onto compare register 1 (address 3), each output bit 0..5 set in both the clear mask (address 6) and the enable mask goes low. If a set and a clear of the same bit coincide, the clear wins.
- R7: Output bit 6 inverts on a compare-register-1 match, and output bit 7 inverts on a compare-register-2 (address 4) match.
- R8: Flags are visible on `irq_o` and at address 8. Bits 3:0 are the capture channels and bits 6:4 are compare matches 0..2. Each flag stays set until a one is written to its bit at address 8.
- R9: After reset, the outputs, flags, capture latches and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| ev_i | input | 1 | External count event |
| trst_i | input | 1 | Timer reset, rising-edge active |
| cap_i | input | 4 | Capture inputs |
| out_o | output | 8 | Match-driven output bits |
| irq_o | output | 7 | Sticky interrupt flags |

## Verification
Two behaviours are hard to reach from the ports, because a free-running count makes the timer value at any edge depend on pipeline latency:

- landing a capture and a match on an exactly known timer value;
- making a set and a clear of the same output bit coincide.

The bench handles both the same way. It switches to event counting and freezes the timer, clears it with the reset input, and then advances it one event pulse at a time. Every capture and match then happens at a value the bench knows in advance. Putting both compare registers at the same value then produces the set/clear collision on demand.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_EDGE  = 4'd1;
  localparam logic [AW-1:0] A_CMP0  = 4'd2;
  localparam logic [AW-1:0] A_SETM  = 4'd5;
  localparam logic [AW-1:0] A_CLRM  = 4'd6;
  localparam logic [AW-1:0] A_OUTEN = 4'd7;
  localparam logic [AW-1:0] A_FLAGS = 4'd8;
  localparam logic [AW-1:0] A_TIMER = 4'd9;
  localparam logic [AW-1:0] A_CAP0  = 4'd10;
endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    edge_sel_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [TW-1:0] timer_i,
  output logic [TW-1:0] cap_o,
  output logic          hit_o
);
  assign hit_o = (edge_sel_i[0] & rise_i) | (edge_sel_i[1] & fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (hit_o) cap_o <= timer_i;
  end

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cap_o == $past(timer_i));
  assert_capture_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable(cap_o));
endmodule

// File: rtl/cct_match_out.sv
module cct_match_out #(
  parameter int unsigned TW   = 16,
  parameter int unsigned NCMP = 3,
  parameter int unsigned NSR  = 6,
  localparam int unsigned NOUT = NSR + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCMP-1:0][TW-1:0]   cmp_i,
  input  logic                      inc_i,
  input  logic [TW-1:0]             nxt_i,
  input  logic [NSR-1:0]            set_msk_i,
  input  logic [NSR-1:0]            clr_msk_i,
  input  logic [NSR-1:0]            en_i,
  output logic [NCMP-1:0]           match_o,
  output logic [NOUT-1:0]           out_o
);
  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign match_o[k] = inc_i & (nxt_i == cmp_i[k]);
  end

  logic [NSR-1:0] set_v, clr_v;
  assign set_v = match_o[0] ? (set_msk_i & en_i) : '0;
  assign clr_v = match_o[1] ? (clr_msk_i & en_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= '0;
    else begin
      out_o[NSR-1:0] <= (out_o[NSR-1:0] | set_v) & ~clr_v;  // clear wins
      if (match_o[1])      out_o[NSR]   <= ~out_o[NSR];
      if (match_o[NCMP-1]) out_o[NSR+1] <= ~out_o[NSR+1];
    end
  end

  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o[0] && !match_o[1] |=> (out_o[NSR-1:0] & $past(set_msk_i & en_i)) == $past(set_msk_i & en_i));
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o[1] |=> (out_o[NSR-1:0] & $past(clr_msk_i & en_i)) == '0);
  assert_disabled_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (out_o[NSR-1:0] & ~$past(en_i)) == ($past(out_o[NSR-1:0]) & ~$past(en_i)));
  assert_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o[NCMP-1] |=> out_o[NSR+1] != $past(out_o[NSR+1]));
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int unsigned TW   = 16,
  parameter int unsigned NCAP = 4,
  parameter int unsigned NCMP = 3,
  parameter int unsigned NSR  = 6,
  localparam int unsigned NOUT = NSR + 2,
  localparam int unsigned NFLG = NCAP + NCMP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [TW-1:0]   wdata_i,
  output logic [TW-1:0]   rdata_o,
  input  logic            ev_i,
  input  logic            trst_i,
  input  logic [NCAP-1:0] cap_i,
  output logic [NOUT-1:0] out_o,
  output logic [NFLG-1:0] irq_o
);
  logic                    ext_sel_q;
  logic [2*NCAP-1:0]       edge_q;
  logic [NCMP-1:0][TW-1:0] cmp_q;
  logic [NSR-1:0]          setm_q, clrm_q, en_q;
  logic [NFLG-1:0]         flags_q, flg_clr;
  logic [TW-1:0]           timer_q, timer_nxt, timer_inc;
  logic [NCAP-1:0][TW-1:0] cap_v;
  logic [NCAP-1:0]         cap_hit;
  logic [NCMP-1:0]         match;
  logic                    tick, inc;

  logic [NCAP+1:0] rise, fall;
  cct_sync_edge #(.W(NCAP+2)) u_sync (
    .clk_i, .rst_ni,
    .d_i   ({trst_i, ev_i, cap_i}),
    .rise_o(rise),
    .fall_o(fall)
  );
  wire ev_rise = rise[NCAP];
  wire rt_rise = rise[NCAP+1];

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sel_q <= 1'b0;
      edge_q    <= '0;
      cmp_q     <= '0;
      setm_q    <= '0;
      clrm_q    <= '0;
      en_q      <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL)  ext_sel_q <= wdata_i[0];
      if (addr_i == A_EDGE)  edge_q    <= wdata_i[2*NCAP-1:0];
      if (addr_i == A_SETM)  setm_q    <= wdata_i[NSR-1:0];
      if (addr_i == A_CLRM)  clrm_q    <= wdata_i[NSR-1:0];
      if (addr_i == A_OUTEN) en_q      <= wdata_i[NSR-1:0];
      for (int k = 0; k < NCMP; k++)
        if (addr_i == A_CMP0 + AW'(k)) cmp_q[k] <= wdata_i;
    end
  end

  // Timer
  assign tick      = ext_sel_q ? ev_rise : 1'b1;
  assign inc       = tick & ~rt_rise;
  assign timer_inc = timer_q + 1'b1;
  assign timer_nxt = rt_rise ? '0 : (tick ? timer_inc : timer_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_q <= '0;
    else         timer_q <= timer_nxt;
  end

  // Capture channels
  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    cct_capture #(.TW(TW)) u_cap (
      .clk_i, .rst_ni,
      .edge_sel_i(edge_q[2*i +: 2]),
      .rise_i    (rise[i]),
      .fall_i    (fall[i]),
      .timer_i   (timer_q),
      .cap_o     (cap_v[i]),
      .hit_o     (cap_hit[i])
    );
  end

  cct_match_out #(.TW(TW), .NCMP(NCMP), .NSR(NSR)) u_out (
    .clk_i, .rst_ni,
    .cmp_i    (cmp_q),
    .inc_i    (inc),
    .nxt_i    (timer_inc),
    .set_msk_i(setm_q),
    .clr_msk_i(clrm_q),
    .en_i     (en_q),
    .match_o  (match),
    .out_o
  );

  // Sticky flags, write one to clear; a new event wins over the clear
  assign flg_clr = (wr_en_i && addr_i == A_FLAGS) ? wdata_i[NFLG-1:0] : '0;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flg_clr) | {match, cap_hit};
  end
  assign irq_o = flags_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[0]          = ext_sel_q;
      A_EDGE:  rdata_o[2*NCAP-1:0] = edge_q;
      A_SETM:  rdata_o[NSR-1:0]    = setm_q;
      A_CLRM:  rdata_o[NSR-1:0]    = clrm_q;
      A_OUTEN: rdata_o[NSR-1:0]    = en_q;
      A_FLAGS: rdata_o[NFLG-1:0]   = flags_q;
      A_TIMER: rdata_o             = timer_q;
      default: begin
        for (int k = 0; k < NCMP; k++)
          if (addr_i == A_CMP0 + AW'(k)) rdata_o = cmp_q[k];
        for (int i = 0; i < NCAP; i++)
          if (addr_i == A_CAP0 + AW'(i)) rdata_o = cap_v[i];
      end
    endcase
  end

  assert_clear_on_trst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_rise |=> timer_q == '0);
  assert_hold_no_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_q && !ev_rise && !rt_rise |=> $stable(timer_q));
  assert_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sel_q && !rt_rise |=> timer_q == $past(timer_q) + 1'b1);
  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q & ~flg_clr) != '0 |=> (flags_q & $past(flags_q & ~flg_clr)) == $past(flags_q & ~flg_clr));
endmodule

// File: tb/cct_timer_tb_top.sv
module cct_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ev = 1'b0, trst = 1'b0;
  logic [3:0]  cap = '0;
  logic [7:0]  out;
  logic [6:0]  irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cct_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ev_i(ev), .trst_i(trst), .cap_i(cap), .out_o(out), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic ev_pulse();
    @(negedge clk); ev = 1'b1;
    repeat (2) @(negedge clk); ev = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cap(input logic [3:0] v);
    @(negedge clk); cap = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R9 out", {8'h0, out}, 16'h0);
    chk("R9 irq", {9'h0, irq}, 16'h0);
    rd(4'd10, d); chk("R9 cap0", d, 16'h0);
    rd(4'd2, d);  chk("R9 cmp0", d, 16'h0);
  endtask

  task automatic t_internal();
    logic [15:0] a, b;
    @(negedge clk); rd(4'd9, a);
    repeat (10) @(negedge clk);
    rd(4'd9, b);
    chk("R1 count delta", b - a, 16'd10);
  endtask

  task automatic t_event_and_trst();
    logic [15:0] d;
    wr(4'd0, 16'h1);
    @(negedge clk); trst = 1'b1;
    repeat (6) @(negedge clk); trst = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd9, d); chk("R3 cleared", d, 16'h0);
    repeat (3) ev_pulse();
    rd(4'd9, d); chk("R2 three events", d, 16'd3);
    @(negedge clk); ev = 1'b1;
    repeat (8) @(negedge clk); ev = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd9, d); chk("R2 held high counts once", d, 16'd4);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    // ch0 rising, ch1 falling, ch2 both, ch3 none
    wr(4'd1, 16'h0039);
    set_cap(4'hF);   // rising at timer 4
    ev_pulse();      // timer 5
    set_cap(4'h0);   // falling at timer 5
    rd(4'd10, d); chk("R4 cap0 rising", d, 16'd4);
    rd(4'd11, d); chk("R4 cap1 falling", d, 16'd5);
    rd(4'd12, d); chk("R4 cap2 both", d, 16'd5);
    rd(4'd13, d); chk("R4 cap3 no edge", d, 16'd0);
    chk("R8 capture flags", {9'h0, irq}, 16'h0007);
    wr(4'd8, 16'h007F);
    @(negedge clk);
    chk("R8 flags cleared", {9'h0, irq}, 16'h0000);
  endtask

  task automatic t_compare();
    logic [15:0] d;
    wr(4'd7, 16'h000F);
    wr(4'd5, 16'h0033);
    wr(4'd6, 16'h0006);
    wr(4'd2, 16'd7);
    wr(4'd3, 16'd9);
    wr(4'd4, 16'd8);
    ev_pulse();  // 6
    chk("R5 no match", {8'h0, out}, 16'h0000);
    ev_pulse();  // 7
    chk("R5 set enabled", {8'h0, out}, 16'h0003);
    ev_pulse();  // 8
    chk("R7 bit7 toggle", {8'h0, out}, 16'h0083);
    ev_pulse();  // 9
    chk("R6 clear and R7 bit6 toggle", {8'h0, out}, 16'h00C1);
    chk("R8 match flags", {9'h0, irq}, 16'h0070);
    wr(4'd2, 16'd11);
    wr(4'd3, 16'd11);
    wr(4'd4, 16'h0100);
    ev_pulse();  // 10
    ev_pulse();  // 11
    chk("R6 clear wins", {8'h0, out}, 16'h0081);
    rd(4'd8, d); chk("R8 flags read port", d, 16'h0070);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal();
    t_event_and_trst();
    t_capture();
    t_compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule